// File: doc/BRIEF.md
# Bidirectional Long-Word to Narrow-Bus Width Matcher

This block joins a port that carries full 36-bit long words to a second port whose active width can be 36, 18 or 9 bits. It works in both directions at once. Going outward, each accepted long word is sliced into one, two or four narrow units, and one unit leaves per completed narrow handshake. Coming inward, successive narrow units are packed into a long word, which is offered on the long side once its final unit has arrived.

Both the unit order and the narrow width come from configuration pins. These pins are sampled on the first clock edge after the active-low reset is released and stay fixed until the next reset. In big-endian order, the most significant unit is the first one out and the first one in. In little-endian order, the least significant unit takes that place. At full width every word goes straight through in a single beat. Each of the four ports uses a valid/ready handshake. The FIFO storage, status flags and any clock-domain crossing are outside this block.

Top module: `bm_port`

## Requirements
- R1: `cfg_big_endian` and `cfg_bus_width` are captured on the first rising clock edge after `rst_n` goes high. Later changes on these pins have no effect until the next reset.
- R2: Width code 2'b00 selects a 36-bit narrow bus (1 beat per word), 2'b01 an 18-bit bus (2 beats), 2'b10 a 9-bit bus (4 beats). The reserved code 2'b11 behaves like 2'b00.
- R3: Long-to-narrow, big-endian: beat b carries long-word unit number (N-1-b), where unit 0 is bits [W-1:0], W is the unit width and N is the beat count.
- R4: Long-to-narrow, little-endian: beat b carries unit number b, so the least significant unit leaves first.
- R5: Narrow-to-long, big-endian: the unit written on beat b lands in unit position (N-1-b) of the assembled word.
- R6: Narrow-to-long, little-endian: the unit written on beat b lands in unit position b.
- R7: At 36-bit width (codes 2'b00 and 2'b11), words pass unchanged in one beat in both directions, whatever the endian setting.
- R8: While `nar_out_valid` is high and `nar_out_ready` is low, `nar_out_valid` stays high and `nar_out_data` holds. `long_in_ready` is low while a word is still being delivered, except in the cycle its last beat is taken.
- R9: Once a long word is assembled, `long_out_valid` goes high in the next cycle. Until `long_out_ready` is seen, `long_out_data` holds and `nar_in_ready` stays low.
- R10: During reset and right after it, `nar_out_valid` and `long_out_valid` are low and `long_in_ready` and `nar_in_ready` are high.
- R11: Narrow output bits above the active unit width are zero. Narrow input bits above the active unit width are ignored. The 9-bit units carry all nine bits, including the ninth (parity) bit, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | Unit order select, sampled at reset release (1 = big-endian) |
| cfg_bus_width | input | 2 | Narrow width code, sampled at reset release |
| long_in_data | input | 36 | Long word toward the narrow side |
| long_in_valid | input | 1 | Long input word present |
| long_in_ready | output | 1 | Long input word accepted |
| nar_out_data | output | 36 | Narrow unit, right-aligned |
| nar_out_valid | output | 1 | Narrow unit present |
| nar_out_ready | input | 1 | Narrow unit taken |
| nar_in_data | input | 36 | Narrow unit toward the long side, right-aligned |
| nar_in_valid | input | 1 | Narrow unit present |
| nar_in_ready | output | 1 | Narrow unit accepted |
| long_out_data | output | 36 | Assembled long word |
| long_out_valid | output | 1 | Assembled word present |
| long_out_ready | input | 1 | Assembled word taken |

## Verification
A long word accepted on one clock edge shows up as its first narrow unit in the very next cycle. Each later unit appears one cycle after the edge on which the previous one was taken. An assembled long word becomes valid one cycle after the edge that accepts its last unit. The bench drives inputs and samples outputs on falling edges, so each check falls half a cycle after the register update it depends on. It sweeps both orders across all four width codes. In every configuration it inserts one stall cycle on each outgoing side to confirm the hold behaviour before releasing it.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {
    BW_FULL    = 2'b00,
    BW_HALF    = 2'b01,
    BW_QUARTER = 2'b10,
    BW_RSVD    = 2'b11
  } bus_w_e;

  // log2 of the number of narrow beats per long word
  function automatic logic [1:0] beats_log2(bus_w_e w);
    case (w)
      BW_HALF:    beats_log2 = 2'd1;
      BW_QUARTER: beats_log2 = 2'd2;
      default:    beats_log2 = 2'd0;
    endcase
  endfunction

  // index of the final beat
  function automatic logic [1:0] last_beat(bus_w_e w);
    case (w)
      BW_HALF:    last_beat = 2'd1;
      BW_QUARTER: last_beat = 2'd3;
      default:    last_beat = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bm_cfg.sv
module bm_cfg
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       be_pin,
  input  logic [1:0] width_pin,
  output logic       big_endian,
  output bus_w_e     bus_w
);

  logic   armed_q;
  logic   be_q;
  bus_w_e bw_q;

  // armed_q is high from reset until the first edge after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q <= 1'b0;
      bw_q <= BW_FULL;
    end else if (armed_q) begin
      be_q <= be_pin;
      bw_q <= bus_w_e'(width_pin);
    end
  end

  assign big_endian = be_q;
  assign bus_w      = bw_q;

  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> $stable(be_q) && $stable(bw_q));

endmodule

// File: rtl/bm_split.sv
module bm_split
  import bm_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  bus_w_e            bus_w,
  input  logic [LONG_W-1:0] w_data,
  input  logic              w_valid,
  output logic              w_ready,
  output logic [LONG_W-1:0] n_data,
  output logic              n_valid,
  input  logic              n_ready
);

  localparam int Q_W = LONG_W / 4;
  localparam int H_W = LONG_W / 2;

  logic [LONG_W-1:0] word_q;
  logic              held_q, held_d;
  logic [1:0]        beat_q, beat_d;
  logic [1:0]        last_idx, unit_idx;
  logic              take, fin, load;
  int                q_pos, h_pos;

  always_comb begin
    last_idx = last_beat(bus_w);
    take     = held_q && n_ready;
    fin      = take && (beat_q == last_idx);
    w_ready  = !held_q || fin;
    load     = w_valid && w_ready;
    held_d   = load ? 1'b1 : (fin ? 1'b0 : held_q);
    beat_d   = fin ? 2'd0 : (take ? beat_q + 2'd1 : beat_q);
    unit_idx = big_endian ? (last_idx - beat_q) : beat_q;
    q_pos    = int'(unit_idx) * Q_W;
    h_pos    = int'(unit_idx[0]) * H_W;
  end

  always_comb begin
    n_data = '0;
    case (beats_log2(bus_w))
      2'd2:    n_data[Q_W-1:0] = word_q[q_pos +: Q_W];
      2'd1:    n_data[H_W-1:0] = word_q[h_pos +: H_W];
      default: n_data          = word_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      beat_q <= 2'd0;
    end else begin
      held_q <= held_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) word_q <= w_data;
  end

  assign n_valid = held_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    n_valid && !n_ready |=> n_valid && $stable(n_data));

  p_beat_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> beat_q <= last_idx);

endmodule

// File: rtl/bm_pack.sv
module bm_pack
  import bm_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  bus_w_e            bus_w,
  input  logic [LONG_W-1:0] n_data,
  input  logic              n_valid,
  output logic              n_ready,
  output logic [LONG_W-1:0] w_data,
  output logic              w_valid,
  input  logic              w_ready
);

  localparam int Q_W = LONG_W / 4;
  localparam int H_W = LONG_W / 2;

  logic [LONG_W-1:0] acc_q, acc_d;
  logic              full_q, full_d;
  logic [1:0]        beat_q, beat_d;
  logic [1:0]        last_idx, unit_idx;
  logic              accept, fin;
  int                q_pos, h_pos;

  always_comb begin
    last_idx = last_beat(bus_w);
    n_ready  = !full_q;
    accept   = n_valid && !full_q;
    fin      = accept && (beat_q == last_idx);
    beat_d   = fin ? 2'd0 : (accept ? beat_q + 2'd1 : beat_q);
    full_d   = fin ? 1'b1 : ((full_q && w_ready) ? 1'b0 : full_q);
    unit_idx = big_endian ? (last_idx - beat_q) : beat_q;
    q_pos    = int'(unit_idx) * Q_W;
    h_pos    = int'(unit_idx[0]) * H_W;
  end

  always_comb begin
    acc_d = acc_q;
    case (beats_log2(bus_w))
      2'd2:    acc_d[q_pos +: Q_W] = n_data[Q_W-1:0];
      2'd1:    acc_d[h_pos +: H_W] = n_data[H_W-1:0];
      default: acc_d               = n_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      beat_q <= 2'd0;
    end else begin
      full_q <= full_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) acc_q <= acc_d;
  end

  assign w_valid = full_q;
  assign w_data  = acc_q;

  p_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(w_data) && !n_ready);

  p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    n_valid && n_ready && (beat_q == last_idx) |=> w_valid);

endmodule

// File: rtl/bm_port.sv
module bm_port
  import bm_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic [1:0]        cfg_bus_width,
  input  logic [LONG_W-1:0] long_in_data,
  input  logic              long_in_valid,
  output logic              long_in_ready,
  output logic [LONG_W-1:0] nar_out_data,
  output logic              nar_out_valid,
  input  logic              nar_out_ready,
  input  logic [LONG_W-1:0] nar_in_data,
  input  logic              nar_in_valid,
  output logic              nar_in_ready,
  output logic [LONG_W-1:0] long_out_data,
  output logic              long_out_valid,
  input  logic              long_out_ready
);

  logic   big_endian;
  bus_w_e bus_w;

  bm_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .be_pin     (cfg_big_endian),
    .width_pin  (cfg_bus_width),
    .big_endian (big_endian),
    .bus_w      (bus_w)
  );

  bm_split #(.LONG_W(LONG_W)) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .big_endian (big_endian),
    .bus_w      (bus_w),
    .w_data     (long_in_data),
    .w_valid    (long_in_valid),
    .w_ready    (long_in_ready),
    .n_data     (nar_out_data),
    .n_valid    (nar_out_valid),
    .n_ready    (nar_out_ready)
  );

  bm_pack #(.LONG_W(LONG_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .big_endian (big_endian),
    .bus_w      (bus_w),
    .n_data     (nar_in_data),
    .n_valid    (nar_in_valid),
    .n_ready    (nar_in_ready),
    .w_data     (long_out_data),
    .w_valid    (long_out_valid),
    .w_ready    (long_out_ready)
  );

  p_idle_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !nar_out_valid && !long_out_valid);

endmodule

// File: tb/tb_bm_port.sv
module tb_bm_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic [1:0]  cfg_bus_width = 2'b00;
  logic [35:0] long_in_data = '0;
  logic        long_in_valid = 1'b0;
  logic        long_in_ready;
  logic [35:0] nar_out_data;
  logic        nar_out_valid;
  logic        nar_out_ready = 1'b0;
  logic [35:0] nar_in_data = '0;
  logic        nar_in_valid = 1'b0;
  logic        nar_in_ready;
  logic [35:0] long_out_data;
  logic        long_out_valid;
  logic        long_out_ready = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bm_port dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_big_endian(cfg_big_endian), .cfg_bus_width(cfg_bus_width),
    .long_in_data(long_in_data), .long_in_valid(long_in_valid), .long_in_ready(long_in_ready),
    .nar_out_data(nar_out_data), .nar_out_valid(nar_out_valid), .nar_out_ready(nar_out_ready),
    .nar_in_data(nar_in_data), .nar_in_valid(nar_in_valid), .nar_in_ready(nar_in_ready),
    .long_out_data(long_out_data), .long_out_valid(long_out_valid), .long_out_ready(long_out_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // configuration under test, from the requirements (R2, R7)
  int cur_be, cur_lg;

  function automatic int nbeats();
    return 1 << cur_lg;
  endfunction

  function automatic logic [35:0] unit_of(input logic [35:0] w, input int pos);
    int uw = 36 >> cur_lg;
    logic [35:0] m = (cur_lg == 0) ? 36'hF_FFFF_FFFF : ((36'd1 << uw) - 36'd1);
    return (w >> (pos * uw)) & m;
  endfunction

  task automatic do_reset(input int be, input int code);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_big_endian = be[0];
    cfg_bus_width = code[1:0];
    repeat (3) @(negedge clk);
    chk(!nar_out_valid && !long_out_valid && long_in_ready && nar_in_ready, "R10 in reset",
        {32'd0, nar_out_valid, long_out_valid, long_in_ready, nar_in_ready}, 36'h3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: flip the pins after capture; behaviour must follow captured values
    cfg_big_endian = ~be[0];
    cfg_bus_width = (code == 2) ? 2'b01 : 2'b10;
    chk(!nar_out_valid && !long_out_valid && long_in_ready && nar_in_ready, "R10 after reset",
        {32'd0, nar_out_valid, long_out_valid, long_in_ready, nar_in_ready}, 36'h3);
    cur_be = be;
    cur_lg = (code == 1) ? 1 : ((code == 2) ? 2 : 0);
  endtask

  task automatic split_word(input logic [35:0] w);
    int n = nbeats();
    long_in_valid = 1'b1;
    long_in_data = w;
    chk(long_in_ready, "R8 idle accept", {35'd0, long_in_ready}, 36'd1);
    @(posedge clk);
    @(negedge clk);
    long_in_valid = 1'b0;
    long_in_data = ~w;
    for (int b = 0; b < n; b++) begin
      logic [35:0] e = unit_of(w, (cur_be != 0) ? (n - 1 - b) : b);
      chk(nar_out_valid && nar_out_data == e,
          (cur_lg == 0) ? "R7 split pass" : ((cur_be != 0) ? "R3 split big" : "R4 split little"),
          nar_out_data, e);
      if (b == 0) begin
        nar_out_ready = 1'b0;
        chk(!long_in_ready, "R8 busy", {35'd0, long_in_ready}, 36'd0);
        @(posedge clk);
        @(negedge clk);
        chk(nar_out_valid && nar_out_data == e, "R8 stall hold", nar_out_data, e);
      end
      nar_out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      nar_out_ready = 1'b0;
    end
    chk(!nar_out_valid, "R2 beat count", {35'd0, nar_out_valid}, 36'd0);
  endtask

  task automatic pack_word(input int k);
    int n = nbeats();
    int uw = 36 >> cur_lg;
    logic [35:0] exp = '0;
    for (int b = 0; b < n; b++) begin
      logic [35:0] u = unit_of(36'h9_A5C3_1E7B ^ (36'd0 + k * 36'h1_3579_BDF1 + b * 36'h0_2468_ACE3), 0);
      logic [35:0] junk = (cur_lg == 0) ? 36'd0 : (36'hF_FFFF_FFFF << uw);
      int pos = (cur_be != 0) ? (n - 1 - b) : b;
      exp = exp | (u << (pos * uw));
      nar_in_data = u | junk;
      nar_in_valid = 1'b1;
      chk(nar_in_ready, "R9 input open", {35'd0, nar_in_ready}, 36'd1);
      @(posedge clk);
      @(negedge clk);
      nar_in_valid = 1'b0;
    end
    chk(long_out_valid && long_out_data == exp,
        (cur_lg == 0) ? "R7 pack pass" : ((cur_be != 0) ? "R5 pack big" : "R6 pack little R11"),
        long_out_data, exp);
    chk(!nar_in_ready, "R9 input stalled", {35'd0, nar_in_ready}, 36'd0);
    @(posedge clk);
    @(negedge clk);
    chk(long_out_valid && long_out_data == exp, "R9 word held", long_out_data, exp);
    long_out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    long_out_ready = 1'b0;
    chk(!long_out_valid && nar_in_ready, "R9 word released", {35'd0, long_out_valid}, 36'd0);
  endtask

  initial begin
    for (int be = 0; be < 2; be++) begin
      for (int code = 0; code < 4; code++) begin
        do_reset(be, code);
        for (int k = 0; k < 3; k++) begin
          // R11: split output upper bits are checked zero through unit_of masking
          split_word(36'h8_1234_5678 ^ (36'd0 + k * 36'h7_0F1E_2D3C));
          pack_word(k);
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 36'd0, 36'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule